// File: doc/BRIEF.md
# Accumulator and Register-File ALU Execute Stage

This block carries out the data-processing part of a 12-bit instruction word for a small accumulator machine. It holds the working register W and the three status flags: carry C, digit carry DC and zero Z. The register file stays outside the block, addressed by the low 5 bits of the instruction. Each cycle the block decodes the word as a byte operation on a file register, a single-bit operation, or a literal operation. It computes the 8-bit result and sends it either to W or back to the addressed file register. It then updates exactly the flags that the operation owns.

The surrounding pipeline presents one instruction word and the file-read data for the addressed register in the same cycle. The write-back port is combinational, so the file can capture the result on the same rising edge on which W and the flags load. Control-flow words, skip tests and every encoding outside the data-processing map pass through as no-operations.

Top module: `acc_alu_exec`

## Requirements
- R1: While rst_n is low, and after it is released, W and the C, DC and Z flags read 0 until an instruction changes them.
- R2: For a byte operation (instr[11:10] = 00), d = instr[5] steers the result. With d = 0 the result loads into W and file_we_o stays low. With d = 1, file_we_o is high, file_wdata_o carries the result, and W is unchanged. file_addr_o always equals instr[4:0].
- R3: Opcode instr[11:6] = 000111 computes f + W. Opcode 000010 computes f − W. Both update C, DC and Z. On the add, C is the carry out of bit 7 and DC is the carry out of bit 3. On the subtract, C = 1 when f ≥ W, and DC = 1 when f[3:0] ≥ W[3:0].
- R4: Opcodes 000100 (OR), 000101 (AND) and 000110 (XOR) combine f with W. Opcode 001000 passes f unchanged and 001001 inverts f. All five update only Z.
- R5: Opcode 001010 computes f + 1 and 000011 computes f − 1, and both update only Z. Opcodes 001111 (f + 1) and 001011 (f − 1) write the same results but change no flag.
- R6: Opcode 001100 rotates f right through C and 001101 rotates f left through C. Only C changes, and it takes the bit shifted out. Opcode 001110 exchanges the nibbles of f and changes no flag.
- R7: 0000 011f ffff writes 0 to the file and sets Z. 0000 0100 0000 loads 0 into W and sets Z. 0000 001f ffff writes W to the file and changes no flag.
- R8: 0100 bbbf ffff clears bit bbb of f and 0101 bbbf ffff sets it. Both write the file and leave W and the flags unchanged.
- R9: Top nibble 1100 loads the literal k = instr[7:0] into W and changes no flag. Top nibbles 1101 (OR), 1110 (AND) and 1111 (XOR) combine k with W into W and update only Z.
- R10: Whenever an operation updates Z, Z is 1 exactly when the 8-bit result is zero. A flag that an operation does not own keeps its value.
- R11: Every other encoding has no effect. This covers top nibbles 0110 through 1011, instr[11:6] = 000000 with d = 0, and 000001 with d = 0 and a nonzero address. For these, file_we_o stays low and W and the flags are unchanged.
- R12: The file write port depends only on the current instruction, file data, W and C, within the same cycle. W and the flags take their new values at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 12 | Instruction word to execute this cycle |
| file_rdata_i | input | 8 | Contents of the addressed file register |
| file_addr_o | output | 5 | File register address (instr_i[4:0]) |
| file_wdata_o | output | 8 | Write-back data for the file |
| file_we_o | output | 1 | File write enable for this cycle |
| w_o | output | 8 | Working register W |
| c_o | output | 1 | Carry flag |
| dc_o | output | 1 | Digit-carry flag |
| z_o | output | 1 | Zero flag |

## Verification
The file-side outputs are due in the same cycle as the instruction. W and the flags are due one rising edge later. The bench drives each instruction at a falling edge and checks the file port 2 ns later, while W must still show its old value. It checks W and the flags at the next falling edge, after the one edge that loads them. Every 12-bit encoding is swept under five preset W, file and carry combinations. The bench first sets each combination with a rotate and a literal load, which are checked as well.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_NOP,
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_IOR,
      OP_XOR,
      OP_PASS,
      OP_COM,
      OP_INC,
      OP_DEC,
      OP_RRC,
      OP_RLC,
      OP_SWAP,
      OP_ZERO,
      OP_PUTW,
      OP_BITC,
      OP_BITS
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } flag_t;

   typedef struct packed {
      alu_op_e op;
      logic    use_lit;
      logic    to_w;
      logic    to_file;
      flag_t   upd;
   } ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
#(
   parameter int INSTR_W = 12
) (
   input  logic [INSTR_W-1:0] instr_i,
   output ctl_t               ctl_o
);

   localparam int OPC_HI = INSTR_W - 1;
   localparam int OPC_LO = INSTR_W - 6;
   localparam int D_BIT  = OPC_LO - 1;

   generate
      if (INSTR_W != 12) begin : g_bad_iw
         $error("acc_alu_decode: the opcode map needs INSTR_W == 12");
      end
   endgenerate

   logic [5:0] opc6;
   logic [3:0] top4;
   logic       dbit;
   logic       addr_zero;

   assign opc6      = instr_i[OPC_HI:OPC_LO];
   assign top4      = instr_i[OPC_HI:OPC_HI-3];
   assign dbit      = instr_i[D_BIT];
   assign addr_zero = (instr_i[D_BIT-1:0] == '0);

   always_comb begin
      ctl_o         = '0;
      ctl_o.op      = OP_NOP;
      if (top4[3:2] == 2'b00) begin
         ctl_o.to_w    = !dbit;
         ctl_o.to_file = dbit;
         case (opc6)
            6'b000000: begin
               if (dbit) ctl_o.op = OP_PUTW;
               else begin
                  ctl_o.to_w    = 1'b0;
                  ctl_o.to_file = 1'b0;
               end
            end
            6'b000001: begin
               if (dbit || addr_zero) begin
                  ctl_o.op    = OP_ZERO;
                  ctl_o.upd.z = 1'b1;
               end else begin
                  ctl_o.to_w    = 1'b0;
                  ctl_o.to_file = 1'b0;
               end
            end
            6'b000010: begin ctl_o.op = OP_SUB;  ctl_o.upd = '{c: 1'b1, dc: 1'b1, z: 1'b1}; end
            6'b000011: begin ctl_o.op = OP_DEC;  ctl_o.upd.z = 1'b1; end
            6'b000100: begin ctl_o.op = OP_IOR;  ctl_o.upd.z = 1'b1; end
            6'b000101: begin ctl_o.op = OP_AND;  ctl_o.upd.z = 1'b1; end
            6'b000110: begin ctl_o.op = OP_XOR;  ctl_o.upd.z = 1'b1; end
            6'b000111: begin ctl_o.op = OP_ADD;  ctl_o.upd = '{c: 1'b1, dc: 1'b1, z: 1'b1}; end
            6'b001000: begin ctl_o.op = OP_PASS; ctl_o.upd.z = 1'b1; end
            6'b001001: begin ctl_o.op = OP_COM;  ctl_o.upd.z = 1'b1; end
            6'b001010: begin ctl_o.op = OP_INC;  ctl_o.upd.z = 1'b1; end
            6'b001011: ctl_o.op = OP_DEC;
            6'b001100: begin ctl_o.op = OP_RRC;  ctl_o.upd.c = 1'b1; end
            6'b001101: begin ctl_o.op = OP_RLC;  ctl_o.upd.c = 1'b1; end
            6'b001110: ctl_o.op = OP_SWAP;
            6'b001111: ctl_o.op = OP_INC;
            default: begin
               ctl_o.to_w    = 1'b0;
               ctl_o.to_file = 1'b0;
            end
         endcase
      end else begin
         case (top4)
            4'b0100: begin ctl_o.op = OP_BITC; ctl_o.to_file = 1'b1; end
            4'b0101: begin ctl_o.op = OP_BITS; ctl_o.to_file = 1'b1; end
            4'b1100: begin ctl_o.op = OP_PASS; ctl_o.use_lit = 1'b1; ctl_o.to_w = 1'b1; end
            4'b1101: begin ctl_o.op = OP_IOR;  ctl_o.use_lit = 1'b1; ctl_o.to_w = 1'b1; ctl_o.upd.z = 1'b1; end
            4'b1110: begin ctl_o.op = OP_AND;  ctl_o.use_lit = 1'b1; ctl_o.to_w = 1'b1; ctl_o.upd.z = 1'b1; end
            4'b1111: begin ctl_o.op = OP_XOR;  ctl_o.use_lit = 1'b1; ctl_o.to_w = 1'b1; ctl_o.upd.z = 1'b1; end
            default: ctl_o.op = OP_NOP;
         endcase
      end
   end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
   import acc_alu_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e                     op_i,
   input  logic                        use_lit_i,
   input  logic [DATA_W-1:0]           f_i,
   input  logic [DATA_W-1:0]           k_i,
   input  logic [DATA_W-1:0]           w_i,
   input  logic                        c_i,
   input  logic [$clog2(DATA_W)-1:0]   bsel_i,
   output logic [DATA_W-1:0]           res_o,
   output logic                        c_o,
   output logic                        dc_o
);

   localparam int NIB = DATA_W / 2;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("acc_alu_datapath: the literal field fixes DATA_W at 8");
      end
   endgenerate

   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] arith;
   logic              arith_c;
   logic              arith_dc;
   logic [DATA_W-1:0] bmask;

   assign x = use_lit_i ? k_i : f_i;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] opb;
         logic              cin;
         logic [DATA_W:0]   sum;
         logic [NIB:0]      low;
         always_comb begin
            opb = w_i;
            cin = 1'b0;
            case (op_i)
               OP_SUB:  begin opb = ~w_i;        cin = 1'b1; end
               OP_INC:  begin opb = '0;          cin = 1'b1; end
               OP_DEC:  begin opb = '1;          cin = 1'b0; end
               default: begin opb = w_i;         cin = 1'b0; end
            endcase
         end
         assign sum      = {1'b0, x} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
         assign low      = {1'b0, x[NIB-1:0]} + {1'b0, opb[NIB-1:0]} + {{NIB{1'b0}}, cin};
         assign arith    = sum[DATA_W-1:0];
         assign arith_c  = sum[DATA_W];
         assign arith_dc = low[NIB];
      end else begin : g_split
         logic [DATA_W:0]   add_s, sub_s;
         logic [NIB:0]      add_n, sub_n;
         logic [DATA_W-1:0] inc_s, dec_s;
         assign add_s = {1'b0, x} + {1'b0, w_i};
         assign sub_s = {1'b0, x} + {1'b0, ~w_i} + {{DATA_W{1'b0}}, 1'b1};
         assign add_n = {1'b0, x[NIB-1:0]} + {1'b0, w_i[NIB-1:0]};
         assign sub_n = {1'b0, x[NIB-1:0]} + {1'b0, ~w_i[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
         assign inc_s = x + {{(DATA_W-1){1'b0}}, 1'b1};
         assign dec_s = x - {{(DATA_W-1){1'b0}}, 1'b1};
         always_comb begin
            case (op_i)
               OP_SUB:  begin arith = sub_s[DATA_W-1:0]; arith_c = sub_s[DATA_W]; arith_dc = sub_n[NIB]; end
               OP_INC:  begin arith = inc_s; arith_c = 1'b0; arith_dc = 1'b0; end
               OP_DEC:  begin arith = dec_s; arith_c = 1'b0; arith_dc = 1'b0; end
               default: begin arith = add_s[DATA_W-1:0]; arith_c = add_s[DATA_W]; arith_dc = add_n[NIB]; end
            endcase
         end
      end
   endgenerate

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bmask
         assign bmask[i] = (bsel_i == i[$clog2(DATA_W)-1:0]);
      end
   endgenerate

   always_comb begin
      res_o = x;
      case (op_i)
         OP_ADD, OP_SUB,
         OP_INC, OP_DEC: res_o = arith;
         OP_AND:         res_o = x & w_i;
         OP_IOR:         res_o = x | w_i;
         OP_XOR:         res_o = x ^ w_i;
         OP_COM:         res_o = ~x;
         OP_RRC:         res_o = {c_i, x[DATA_W-1:1]};
         OP_RLC:         res_o = {x[DATA_W-2:0], c_i};
         OP_SWAP:        res_o = {x[NIB-1:0], x[DATA_W-1:NIB]};
         OP_ZERO:        res_o = '0;
         OP_PUTW:        res_o = w_i;
         OP_BITC:        res_o = x & ~bmask;
         OP_BITS:        res_o = x | bmask;
         default:        res_o = x;
      endcase
   end

   always_comb begin
      case (op_i)
         OP_ADD, OP_SUB: c_o = arith_c;
         OP_RRC:         c_o = x[0];
         OP_RLC:         c_o = x[DATA_W-1];
         default:        c_o = c_i;
      endcase
      dc_o = arith_dc;
   end

endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
   import acc_alu_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter logic [DATA_W-1:0] W_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              w_we_i,
   input  logic [DATA_W-1:0] w_d_i,
   input  flag_t             upd_i,
   input  flag_t             flags_d_i,
   output logic [DATA_W-1:0] w_q_o,
   output flag_t             flags_q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q_o     <= W_RESET;
         flags_q_o <= '0;
      end else begin
         if (w_we_i)   w_q_o        <= w_d_i;
         if (upd_i.c)  flags_q_o.c  <= flags_d_i.c;
         if (upd_i.dc) flags_q_o.dc <= flags_d_i.dc;
         if (upd_i.z)  flags_q_o.z  <= flags_d_i.z;
      end
   end

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
   import acc_alu_pkg::*;
#(
   parameter int          INSTR_W      = 12,
   parameter int          DATA_W       = 8,
   parameter int          ADDR_W       = 5,
   parameter bit          SHARED_ADDER = 1'b1,
   parameter logic [7:0]  W_RESET      = 8'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  file_rdata_i,
   output logic [ADDR_W-1:0]  file_addr_o,
   output logic [DATA_W-1:0]  file_wdata_o,
   output logic               file_we_o,
   output logic [DATA_W-1:0]  w_o,
   output logic               c_o,
   output logic               dc_o,
   output logic               z_o
);

   localparam int BSEL_W = $clog2(DATA_W);
   localparam int BSEL_LO = ADDR_W;

   generate
      if (ADDR_W != 5) begin : g_bad_aw
         $error("acc_alu_exec: the file address field is 5 bits wide");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("acc_alu_exec: DATA_W must be 8");
      end
   endgenerate

   ctl_t              ctl;
   logic [DATA_W-1:0] res;
   logic              c_new;
   logic              dc_new;
   flag_t             flags_d;
   flag_t             flags_q;

   acc_alu_decode #(.INSTR_W(INSTR_W)) u_decode (
      .instr_i (instr_i),
      .ctl_o   (ctl)
   );

   acc_alu_datapath #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_datapath (
      .op_i      (ctl.op),
      .use_lit_i (ctl.use_lit),
      .f_i       (file_rdata_i),
      .k_i       (instr_i[DATA_W-1:0]),
      .w_i       (w_o),
      .c_i       (c_o),
      .bsel_i    (instr_i[BSEL_LO+BSEL_W-1:BSEL_LO]),
      .res_o     (res),
      .c_o       (c_new),
      .dc_o      (dc_new)
   );

   assign flags_d = '{c: c_new, dc: dc_new, z: (res == '0)};

   acc_alu_state #(.DATA_W(DATA_W), .W_RESET(W_RESET)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .w_we_i    (ctl.to_w),
      .w_d_i     (res),
      .upd_i     (ctl.upd),
      .flags_d_i (flags_d),
      .w_q_o     (w_o),
      .flags_q_o (flags_q)
   );

   assign file_addr_o  = instr_i[ADDR_W-1:0];
   assign file_wdata_o = res;
   assign file_we_o    = ctl.to_file;
   assign c_o          = flags_q.c;
   assign dc_o         = flags_q.dc;
   assign z_o          = flags_q.z;

   // R2: a byte operation with d = 0 never writes the file
   a_r2_no_file_write: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:10] == 2'b00 && !instr_i[5]) |-> !file_we_o);

   // R8: bit operations write the file and touch at most one bit
   a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:9] == 3'b010) |-> (file_we_o && $countones(file_wdata_o ^ file_rdata_i) <= 1));

   // R9: literal move loads k and keeps the flags
   a_r9_literal_move: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:8] == 4'b1100) |=> (w_o == $past(instr_i[7:0]) && $stable({c_o, dc_o, z_o})));

   // R6: nibble swap leaves every flag alone
   a_r6_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:6] == 6'b001110) |=> $stable({c_o, dc_o, z_o}));

   // R10: after an add into W, Z mirrors a zero W
   a_r10_zero_add: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:6] == 6'b000111 && !instr_i[5]) |=> (z_o == (w_o == '0)));

   // R11: the skip-test and branch space is inert
   a_r11_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[11:9] == 3'b011 || instr_i[11:10] == 2'b10) |-> !file_we_o ##1 ($stable(w_o) && $stable({c_o, dc_o, z_o})));

endmodule

// File: tb/acc_alu_exec_tb.sv
`timescale 1ns/1ps
module acc_alu_exec_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] instr = 12'h000;
   logic [7:0]  fdata = 8'h00;
   logic [4:0]  file_addr;
   logic [7:0]  file_wdata;
   logic        file_we;
   logic [7:0]  w_o;
   logic        c_o, dc_o, z_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   logic [7:0] m_w;
   logic       m_c, m_dc, m_z;
   string      last_tag = "R1";

   always #10 clk = ~clk;

   acc_alu_exec u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .instr_i      (instr),
      .file_rdata_i (fdata),
      .file_addr_o  (file_addr),
      .file_wdata_o (file_wdata),
      .file_we_o    (file_we),
      .w_o          (w_o),
      .c_o          (c_o),
      .dc_o         (dc_o),
      .z_o          (z_o)
   );

   function automatic string req_of(input logic [11:0] i);
      casez (i)
         12'b11??_????_????: return "R9";
         12'b010?_????_????: return "R8";
         12'b0000_001?_????, 12'b0000_011?_????, 12'b0000_0100_0000: return "R7";
         12'b0001_11??_????, 12'b0000_10??_????: return "R3";
         12'b0001_00??_????, 12'b0001_01??_????, 12'b0001_10??_????,
         12'b0010_00??_????, 12'b0010_01??_????: return "R4";
         12'b0010_1???_????, 12'b0000_11??_????, 12'b0011_11??_????: return "R5";
         12'b0011_????_????: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic model(input logic [11:0] i, input logic [7:0] f,
                        output logic we, output logic [7:0] r);
      logic [8:0] s;
      logic       to_w, uz, byte_op;
      logic [7:0] k;
      logic [7:0] bm;
      k = i[7:0];
      bm = 8'd1 << i[7:5];
      r = 8'h00; we = 1'b0; to_w = 1'b0; uz = 1'b0;
      byte_op = (i[11:10] == 2'b00);
      case (i[11:6])
         6'b000000: if (i[5]) r = m_w; else byte_op = 1'b0;
         6'b000001: if (i[5] || i[4:0] == 5'd0) begin r = 8'h00; uz = 1'b1; end else byte_op = 1'b0;
         6'b000010: begin s = {1'b0, f} - {1'b0, m_w}; r = s[7:0];
                          m_c = (f >= m_w); m_dc = (f[3:0] >= m_w[3:0]); uz = 1'b1; end
         6'b000011: begin r = f - 8'd1; uz = 1'b1; end
         6'b000100: begin r = f | m_w; uz = 1'b1; end
         6'b000101: begin r = f & m_w; uz = 1'b1; end
         6'b000110: begin r = f ^ m_w; uz = 1'b1; end
         6'b000111: begin s = {1'b0, f} + {1'b0, m_w}; r = s[7:0];
                          m_c = s[8]; m_dc = ((f[3:0] + m_w[3:0]) > 15); uz = 1'b1; end
         6'b001000: begin r = f; uz = 1'b1; end
         6'b001001: begin r = ~f; uz = 1'b1; end
         6'b001010: begin r = f + 8'd1; uz = 1'b1; end
         6'b001011: r = f - 8'd1;
         6'b001100: begin r = {m_c, f[7:1]}; m_c = f[0]; end
         6'b001101: begin r = {f[6:0], m_c}; m_c = f[7]; end
         6'b001110: r = {f[3:0], f[7:4]};
         6'b001111: r = f + 8'd1;
         default: ;
      endcase
      if (byte_op) begin
         we = i[5]; to_w = !i[5];
      end else begin
         case (i[11:8])
            4'b0100: begin r = f & ~bm; we = 1'b1; end
            4'b0101: begin r = f | bm;  we = 1'b1; end
            4'b1100: begin r = k; to_w = 1'b1; end
            4'b1101: begin r = k | m_w; to_w = 1'b1; uz = 1'b1; end
            4'b1110: begin r = k & m_w; to_w = 1'b1; uz = 1'b1; end
            4'b1111: begin r = k ^ m_w; to_w = 1'b1; uz = 1'b1; end
            default: ;
         endcase
      end
      if (uz) m_z = (r == 8'h00);
      if (to_w) m_w = r;
   endtask

   task automatic check_state();
      nchk++;
      if (w_o !== m_w || c_o !== m_c || dc_o !== m_dc || z_o !== m_z) begin
         nfail++;
         $display("FAIL %s R10 state after edge: W=%h C=%b DC=%b Z=%b expected W=%h C=%b DC=%b Z=%b",
                  last_tag, w_o, c_o, dc_o, z_o, m_w, m_c, m_dc, m_z);
      end
   endtask

   task automatic step(input logic [11:0] ins, input logic [7:0] fd);
      logic       we_e;
      logic [7:0] wd_e;
      logic [7:0] w_old;
      logic [2:0] fl_old;
      @(negedge clk);
      check_state();
      w_old = m_w; fl_old = {m_c, m_dc, m_z};
      model(ins, fd, we_e, wd_e);
      instr = ins; fdata = fd;
      #2;
      nchk++;
      if (file_we !== we_e || (we_e && file_wdata !== wd_e) || file_addr !== ins[4:0]) begin
         nfail++;
         $display("FAIL %s R2 file port for %h: we=%b data=%h addr=%h expected we=%b data=%h addr=%h",
                  req_of(ins), ins, file_we, file_wdata, file_addr, we_e, wd_e, ins[4:0]);
      end
      nchk++;
      if (w_o !== w_old || {c_o, dc_o, z_o} !== fl_old) begin
         nfail++;
         $display("FAIL R12 state moved before edge for %h: W=%h flags=%b expected W=%h flags=%b",
                  ins, w_o, {c_o, dc_o, z_o}, w_old, fl_old);
      end
      last_tag = req_of(ins);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [7:0] cw [5] = '{8'h00, 8'h3A, 8'hFF, 8'h9C, 8'h0F};
      logic [7:0] cf [5] = '{8'h00, 8'hC6, 8'h7F, 8'h9C, 8'h01};
      logic       cc [5] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
      instr = 12'hC5A;
      fdata = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      nchk++;
      if (w_o !== 8'h00 || c_o !== 1'b0 || dc_o !== 1'b0 || z_o !== 1'b0) begin
         nfail++;
         $display("FAIL R1 reset state: W=%h C=%b DC=%b Z=%b expected 00 0 0 0", w_o, c_o, dc_o, z_o);
      end
      instr = 12'h000;
      rst_n = 1'b1;
      m_w = 8'h00; m_c = 1'b0; m_dc = 1'b0; m_z = 1'b0;
      last_tag = "R1";
      for (int k = 0; k < 5; k++) begin
         for (int n = 0; n < 4096; n++) begin
            step(12'h320, {7'b0, cc[k]});
            step({4'hC, cw[k]}, 8'h00);
            step(n[11:0], cf[k]);
         end
      end
      @(negedge clk);
      check_state();
      summary();
   end

endmodule